// File: doc/BRIEF.md
# Depth-Banked, Width-Sliced Synchronous Memory

This block assembles one large single-port synchronous memory from a grid of small, identical-depth RAM tiles. Tiles are stacked in depth: each group of tiles (a depth bank) owns one contiguous span of the address space. Within a bank, the data word is cut into side-by-side slices, and each slice is stored in its own tile. The low address bits go to every tile unchanged. The high address bits choose which bank is active.

Each tile returns read data one clock after the access, so the read path cannot pick a bank from the address that is live at that point. The bank number is therefore captured into a register whenever a read is issued. That register steers the output multiplexer in the following cycle. While no read is issued, the captured bank number and every tile output hold. The read word then stays unchanged, however the address moves. Writes use the live bank decode gated by the port enables. If the memory is no deeper than one tile, the bank decode and the capture register are left out.

Top module: `banked_mem`

## Requirements
- R1: After synchronous reset, `rdata` is all zeros and the captured bank number is zero.
- R2: A read issued in one cycle (`ce` and `re` both high) places the stored word of `addr` on `rdata` after the next rising clock edge. The bank is `addr[ADDR_W-1:TILE_ADDR_W]`, and bank i holds addresses i*TILE_DEPTH to (i+1)*TILE_DEPTH-1.
- R3: Every bit of a word is stored and returned. This includes the top slice, which is narrower than a tile when the word width is not a multiple of the tile width. Slice 0 carries the least significant bits.
- R4: The captured bank number loads the address's bank only in cycles where the read condition holds, and otherwise keeps its value. With both enables present, the read condition is `ce` AND `re`; with one enable present, it is that enable alone; with neither, it is always true.
- R5: A word is written only when `ce` and `we` are both high. With `ce` low, `we` changes no stored word.
- R6: While the read condition is false, `rdata` holds its last value, even if `addr` moves to other banks.
- R7: Back-to-back reads to different banks each return their own word in consecutive cycles.
- R8: A read and a write to the same address in the same cycle return the old content; the new content is returned by the next read.
- R9: The same in-bank offset in different banks is stored separately, and no bank aliases another.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | ADDR_W | Word address |
| wdata | input | TOTAL_WIDTH | Write data |
| we | input | 1 | Write request |
| ce | input | 1 | Chip enable (used when HAS_CE is nonzero) |
| re | input | 1 | Read enable (used when HAS_RE is nonzero) |
| rdata | output | TOTAL_WIDTH | Read data, one cycle after the read |

## Verification
A wrong captured bank number shows at the port as a whole word taken from the wrong bank. The error appears at the edge after the faulty read, or after a run of idle cycles if the register loaded when it should have held. A tile that misses a write, or a slice that is wired in the wrong place, shows up on the first later read of that address as a corrupted bit field. The bench compares every cycle's `rdata` against a flat reference array, so any such fault appears within one cycle of the read that exposes it.

// File: rtl/bmem_pkg.sv
package bmem_pkg;

    typedef enum logic [1:0] {
        RD_ALWAYS  = 2'd0,
        RD_CE_ONLY = 2'd1,
        RD_RE_ONLY = 2'd2,
        RD_CE_RE   = 2'd3
    } rd_mode_e;

    function automatic int addr_bits(input int depth);
        return (depth <= 2) ? 1 : $clog2(depth);
    endfunction

    function automatic int ceil_div(input int a, input int b);
        return (a + b - 1) / b;
    endfunction

    // width of slice s when the word is cut into tile-wide pieces
    function automatic int slice_width(input int total, input int tile, input int s);
        int rest;
        rest = total - s * tile;
        return (rest < tile) ? rest : tile;
    endfunction

    function automatic rd_mode_e pick_mode(input int has_ce, input int has_re);
        if (has_ce != 0 && has_re != 0) return RD_CE_RE;
        if (has_ce != 0)                return RD_CE_ONLY;
        if (has_re != 0)                return RD_RE_ONLY;
        return RD_ALWAYS;
    endfunction

endpackage

// File: rtl/bmem_tile_ram.sv
module bmem_tile_ram #(
    parameter int DEPTH  = 64,
    parameter int WIDTH  = 8,
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_en,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [WIDTH-1:0]  wdata,
    output logic [WIDTH-1:0]  rdata
);
    logic [WIDTH-1:0] store [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            store[addr] <= wdata;
        end
    end

    // read register: old content on a same-cycle write, holds when idle
    always_ff @(posedge clk) begin
        if (rst) begin
            rdata <= '0;
        end else if (rd_en) begin
            rdata <= store[addr];
        end
    end
endmodule

// File: rtl/bmem_enable_decode.sv
module bmem_enable_decode #(
    parameter int HAS_CE    = 1,
    parameter int HAS_RE    = 1,
    parameter int NUM_BANKS = 4,
    parameter int SEL_W     = 2
) (
    input  logic                 ce,
    input  logic                 re,
    input  logic                 we,
    input  logic [SEL_W-1:0]     bank_idx,
    output logic                 rd_cond,
    output logic [NUM_BANKS-1:0] rd_hit,
    output logic [NUM_BANKS-1:0] wr_hit
);
    import bmem_pkg::*;

    localparam rd_mode_e MODE = pick_mode(HAS_CE, HAS_RE);

    logic chip_on;
    logic wr_cond;
    logic [NUM_BANKS-1:0] bank_live;

    always_comb begin
        unique case (MODE)
            RD_CE_RE:   rd_cond = ce & re;
            RD_CE_ONLY: rd_cond = ce;
            RD_RE_ONLY: rd_cond = re;
            default:    rd_cond = 1'b1;
        endcase
    end

    assign chip_on = (HAS_CE != 0) ? ce : 1'b1;
    assign wr_cond = chip_on & we;

    generate
        if (NUM_BANKS == 1) begin : g_single
            assign bank_live = 1'b1;
        end else begin : g_multi
            for (genvar b = 0; b < NUM_BANKS; b++) begin : g_cmp
                assign bank_live[b] = (bank_idx == SEL_W'(b));
            end
        end
    endgenerate

    assign rd_hit = bank_live & {NUM_BANKS{rd_cond}};
    assign wr_hit = bank_live & {NUM_BANKS{wr_cond}};
endmodule

// File: rtl/bmem_sel_reg.sv
module bmem_sel_reg #(
    parameter int SEL_W = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [SEL_W-1:0] d,
    output logic [SEL_W-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else if (load) begin
            q <= d;
        end
    end
endmodule

// File: rtl/bmem_read_mux.sv
module bmem_read_mux #(
    parameter int NUM_BANKS = 4,
    parameter int SEL_W     = 2,
    parameter int WIDTH     = 20
) (
    input  logic [NUM_BANKS*WIDTH-1:0] words,
    input  logic [SEL_W-1:0]           sel,
    output logic [WIDTH-1:0]           out
);
    generate
        if (NUM_BANKS == 1) begin : g_pass
            assign out = words;
        end else begin : g_andor
            always_comb begin
                out = '0;
                for (int b = 0; b < NUM_BANKS; b++) begin
                    if (sel == SEL_W'(b)) begin
                        out = out | words[b*WIDTH +: WIDTH];
                    end
                end
            end
        end
    endgenerate
endmodule

// File: rtl/banked_mem.sv
module banked_mem #(
    parameter int TOTAL_DEPTH = 256,
    parameter int TOTAL_WIDTH = 20,
    parameter int TILE_DEPTH  = 64,
    parameter int TILE_WIDTH  = 8,
    parameter int HAS_CE      = 1,
    parameter int HAS_RE      = 1,
    localparam int ADDR_W     = bmem_pkg::addr_bits(TOTAL_DEPTH)
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [ADDR_W-1:0]      addr,
    input  logic [TOTAL_WIDTH-1:0] wdata,
    input  logic                   we,
    input  logic                   ce,
    input  logic                   re,
    output logic [TOTAL_WIDTH-1:0] rdata
);
    localparam int TILE_ADDR_W = bmem_pkg::addr_bits(TILE_DEPTH);
    localparam int NUM_BANKS   = TOTAL_DEPTH / TILE_DEPTH;
    localparam int NUM_SLICES  = bmem_pkg::ceil_div(TOTAL_WIDTH, TILE_WIDTH);
    localparam int BANK_BITS   = ADDR_W - TILE_ADDR_W;
    localparam int SEL_W       = (BANK_BITS > 0) ? BANK_BITS : 1;

    logic [TILE_ADDR_W-1:0]           tile_addr;
    logic [SEL_W-1:0]                 bank_idx;
    logic [SEL_W-1:0]                 sel_q;
    logic                             rd_cond;
    logic [NUM_BANKS-1:0]             rd_hit;
    logic [NUM_BANKS-1:0]             wr_hit;
    logic [NUM_BANKS*TOTAL_WIDTH-1:0] bank_words;

    assign tile_addr = addr[TILE_ADDR_W-1:0];

    generate
        if (BANK_BITS > 0) begin : g_bank_idx
            assign bank_idx = addr[ADDR_W-1:TILE_ADDR_W];
        end else begin : g_no_bank_idx
            assign bank_idx = '0;
        end
    endgenerate

    bmem_enable_decode #(
        .HAS_CE    (HAS_CE),
        .HAS_RE    (HAS_RE),
        .NUM_BANKS (NUM_BANKS),
        .SEL_W     (SEL_W)
    ) u_decode (
        .ce       (ce),
        .re       (re),
        .we       (we),
        .bank_idx (bank_idx),
        .rd_cond  (rd_cond),
        .rd_hit   (rd_hit),
        .wr_hit   (wr_hit)
    );

    // captured bank number, only present when there is more than one bank
    generate
        if (NUM_BANKS > 1) begin : g_sel
            bmem_sel_reg #(.SEL_W(SEL_W)) u_sel (
                .clk  (clk),
                .rst  (rst),
                .load (rd_cond),
                .d    (bank_idx),
                .q    (sel_q)
            );
        end else begin : g_no_sel
            assign sel_q = '0;
        end
    endgenerate

    // tile grid: banks in depth, slices in width
    generate
        for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
            logic [TOTAL_WIDTH-1:0] bank_word;
            for (genvar s = 0; s < NUM_SLICES; s++) begin : g_slice
                localparam int SW = bmem_pkg::slice_width(TOTAL_WIDTH, TILE_WIDTH, s);
                localparam int LO = s * TILE_WIDTH;
                bmem_tile_ram #(
                    .DEPTH  (TILE_DEPTH),
                    .WIDTH  (SW),
                    .ADDR_W (TILE_ADDR_W)
                ) u_tile (
                    .clk   (clk),
                    .rst   (rst),
                    .rd_en (rd_hit[b]),
                    .wr_en (wr_hit[b]),
                    .addr  (tile_addr),
                    .wdata (wdata[LO +: SW]),
                    .rdata (bank_word[LO +: SW])
                );
            end
            assign bank_words[b*TOTAL_WIDTH +: TOTAL_WIDTH] = bank_word;
        end
    endgenerate

    bmem_read_mux #(
        .NUM_BANKS (NUM_BANKS),
        .SEL_W     (SEL_W),
        .WIDTH     (TOTAL_WIDTH)
    ) u_mux (
        .words (bank_words),
        .sel   (sel_q),
        .out   (rdata)
    );
endmodule

// File: rtl/banked_mem_chk.sv
module banked_mem_chk #(
    parameter int TOTAL_DEPTH = 256,
    parameter int TOTAL_WIDTH = 20,
    parameter int TILE_DEPTH  = 64,
    parameter int HAS_CE      = 1,
    parameter int HAS_RE      = 1,
    parameter int ADDR_W      = 8,
    parameter int TILE_ADDR_W = 6,
    parameter int NUM_BANKS   = 4,
    parameter int SEL_W       = 2
) (
    input logic                   clk,
    input logic                   rst,
    input logic [ADDR_W-1:0]      addr,
    input logic                   ce,
    input logic                   re,
    input logic [TOTAL_WIDTH-1:0] rdata,
    input logic [SEL_W-1:0]       sel_q,
    input logic [NUM_BANKS-1:0]   rd_hit
);
    logic rd_c;
    assign rd_c = ((HAS_CE != 0) ? ce : 1'b1) & ((HAS_RE != 0) ? re : 1'b1);

    assert_rst_zero_R1: assert property (@(posedge clk)
        $fell(rst) |-> (rdata == '0 && sel_q == '0));

    assert_sel_hold_R4: assert property (@(posedge clk) disable iff (rst)
        !rd_c |=> $stable(sel_q));

    assert_out_hold_R6: assert property (@(posedge clk) disable iff (rst)
        !rd_c |=> $stable(rdata));

    assert_one_bank_R2: assert property (@(posedge clk) disable iff (rst)
        $onehot0(rd_hit));

    generate
        if (ADDR_W > TILE_ADDR_W) begin : g_load
            assert_sel_load_R4: assert property (@(posedge clk) disable iff (rst)
                rd_c |=> sel_q == $past(addr[ADDR_W-1:TILE_ADDR_W]));
        end
    endgenerate
endmodule

bind banked_mem banked_mem_chk #(
    .TOTAL_DEPTH (TOTAL_DEPTH),
    .TOTAL_WIDTH (TOTAL_WIDTH),
    .TILE_DEPTH  (TILE_DEPTH),
    .HAS_CE      (HAS_CE),
    .HAS_RE      (HAS_RE),
    .ADDR_W      (ADDR_W),
    .TILE_ADDR_W (TILE_ADDR_W),
    .NUM_BANKS   (NUM_BANKS),
    .SEL_W       (SEL_W)
) chk_i (
    .clk    (clk),
    .rst    (rst),
    .addr   (addr),
    .ce     (ce),
    .re     (re),
    .rdata  (rdata),
    .sel_q  (sel_q),
    .rd_hit (rd_hit)
);

// File: tb/banked_mem_tb_top.sv
`timescale 1ns/1ps
module banked_mem_tb_top;
    localparam int DEPTH = 256;
    localparam int WIDTH = 20;
    localparam int AW    = 8;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic [AW-1:0]    addr = '0;
    logic [WIDTH-1:0] wdata = '0;
    logic             we = 1'b0;
    logic             ce = 1'b0;
    logic             re = 1'b0;
    logic [WIDTH-1:0] rdata;

    logic [WIDTH-1:0] ref_mem [DEPTH];
    logic [WIDTH-1:0] exp_q = '0;
    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    banked_mem #(
        .TOTAL_DEPTH (DEPTH),
        .TOTAL_WIDTH (WIDTH),
        .TILE_DEPTH  (64),
        .TILE_WIDTH  (8),
        .HAS_CE      (1),
        .HAS_RE      (1)
    ) dut_i (
        .clk   (clk),
        .rst   (rst),
        .addr  (addr),
        .wdata (wdata),
        .we    (we),
        .ce    (ce),
        .re    (re),
        .rdata (rdata)
    );

    function automatic logic [WIDTH-1:0] pattern(input int a);
        return WIDTH'((a * 32'h9E37) ^ (a << 11) ^ 32'h5A5A5);
    endfunction

    task automatic check(input string tag, input logic [WIDTH-1:0] act,
                         input logic [WIDTH-1:0] expv);
        n_checks++;
        if (act !== expv) begin
            n_errors++;
            $display("FAIL %s: rdata=%05h expected=%05h", tag, act, expv);
        end
    endtask

    // one clock cycle; model updated before the edge, outputs sampled 1 ns after
    task automatic op(input logic c, input logic r, input logic w,
                      input logic [AW-1:0] a, input logic [WIDTH-1:0] d);
        ce = c; re = r; we = w; addr = a; wdata = d;
        if (c && r) exp_q = ref_mem[a];
        if (c && w) ref_mem[a] = d;
        @(posedge clk);
        #1;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 5);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: rdata=%05h expected=%05h", rdata, exp_q);
        finish_run();
    end

    initial begin
        void'($urandom(32'h1234ABCD));
        for (int i = 0; i < DEPTH; i++) ref_mem[i] = '0;
        repeat (3) @(posedge clk);
        #1;
        rst = 1'b0;
        @(posedge clk);
        #1;
        check("R1 reset value", rdata, '0);

        // fill every address
        for (int i = 0; i < DEPTH; i++) op(1, 0, 1, AW'(i), pattern(i));
        check("R1 output untouched by writes", rdata, '0);

        // R9: same offset in every bank, distinct data
        for (int b = 0; b < 4; b++) op(1, 0, 1, AW'(b * 64 + 9), WIDTH'(20'h11111 * (b + 1)));
        for (int b = 0; b < 4; b++) begin
            op(1, 1, 0, AW'(b * 64 + 9), '0);
            check("R9 bank isolation", rdata, exp_q);
        end

        // R3: full-width and top-slice patterns
        op(1, 0, 1, 8'd5, 20'hFFFFF);
        op(1, 0, 1, 8'd70, 20'hA5A5A);
        op(1, 0, 1, 8'd255, 20'h80001);
        op(1, 1, 0, 8'd5, '0);   check("R3 all ones", rdata, 20'hFFFFF);
        op(1, 1, 0, 8'd70, '0);  check("R3 alternating", rdata, 20'hA5A5A);
        op(1, 1, 0, 8'd255, '0); check("R3 narrow top slice", rdata, 20'h80001);

        // R7: back-to-back across banks
        op(1, 1, 0, 8'd3, '0);   check("R7 bank0", rdata, exp_q);
        op(1, 1, 0, 8'd67, '0);  check("R7 bank1", rdata, exp_q);
        op(1, 1, 0, 8'd131, '0); check("R7 bank2", rdata, exp_q);
        op(1, 1, 0, 8'd195, '0); check("R7 bank3", rdata, exp_q);
        op(1, 1, 0, 8'd10, '0);  check("R7 back to bank0", rdata, pattern(10));

        // R6/R4: idle cycles with moving address keep the word
        op(1, 1, 0, 8'd67, '0);
        check("R2 read bank1", rdata, pattern(67));
        op(1, 0, 0, 8'd200, '0); check("R6 re low", rdata, pattern(67));
        op(0, 1, 0, 8'd130, '0); check("R6 ce low", rdata, pattern(67));
        op(0, 0, 0, 8'd2, '0);   check("R4 selection held", rdata, pattern(67));

        // R5: write without ce is dropped
        op(0, 0, 1, 8'd200, 20'h0BEEF);
        op(1, 1, 0, 8'd200, '0);
        check("R5 write ignored", rdata, pattern(200));

        // R8: read during write
        op(1, 1, 1, 8'd12, 20'h7C0DE);
        check("R8 old data", rdata, pattern(12));
        op(1, 1, 0, 8'd12, '0);
        check("R8 new data", rdata, 20'h7C0DE);

        // constrained random traffic
        for (int k = 0; k < 3000; k++) begin
            logic c, r, w;
            c = ($urandom % 4) != 0;
            r = ($urandom % 2) != 0;
            w = ($urandom % 3) == 0;
            op(c, r, w, AW'($urandom), WIDTH'($urandom));
            check((c && r) ? "R2 random read" : "R6 random idle", rdata, exp_q);
        end

        finish_run();
    end
endmodule